// File: doc/BRIEF.md
# Deep-Sleep Minimum Off-Time Timer

This block drives the enable of a switchable core supply around a low-power state. When the surrounding power controller requests sleep, the block drops the supply enable. In deep mode it also starts a down-counter that enforces a minimum supply-off interval. Wakeup requests that arrive before that interval has elapsed are not acted on. The block keeps the latest one and honours it the moment the interval ends. When deep mode is off, no interval is enforced and a wakeup brings the supply back on the following edge.

The interval length is a programmable count multiplied by a power-of-two tick period, and both are set in one 32-bit control word. A free-running prescaler produces the ticks. It is cleared at every deep entry, so each off period starts from the same tick phase. The count is copied into the down-counter afresh at each entry.

The controller has three states. `ST_POWER_ON` drives the supply enable high. `ST_OFF_HOLD` is the countdown with the supply off. `ST_OFF_READY` has the supply off with the interval met. The transitions are:
- enter-deep: ON to HOLD, on a sleep request with deep mode set.
- enter-shallow: ON to READY, on a sleep request with deep mode clear.
- expire-wake: HOLD to ON, when the count is zero and a wakeup is present or latched.
- expire-idle: HOLD to READY, when the count is zero and no wakeup is present or latched.
- wake: READY to ON, on a wakeup request.

Top module: `dsleep_offtime_timer`

## Requirements
- R1: The control word reads back the tick select in bits 28:24 and the count in bits 23:16 (bit 0 = LSB). All other bits read zero and ignore writes. After reset the word reads 0x0810_0000 (select 8, count 16).
- R2: While the supply is on, a sleep request sampled at a clock edge makes supply_en_o low after that edge.
- R3: A tick select n of 1 to 31 gives a tick every 2^(n-1) clock cycles. A select of 0 behaves like 1.
- R4: In deep mode with count C and tick period P, and a wakeup pending, supply_en_o goes high after the (C*P+1)-th edge following the entry edge.
- R5: A wakeup pulse that arrives while the count is nonzero leaves the supply off. It is latched and served when the count reaches zero.
- R6: In deep mode with a count of zero, a wakeup sampled at the first edge after entry turns the supply on after that edge.
- R7: With deep mode clear, and also in the READY state, a wakeup sampled at an edge turns the supply on after that edge.
- R8: The count and the prescaler phase are reloaded at every deep entry, so repeated entries with the same settings give the same off time.
- R9: If the count expires with no wakeup seen, the supply stays off until a wakeup request arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr_en | input | 1 | Control word write strobe |
| cfg_wr_data | input | 32 | Control word write data |
| cfg_rd_data | output | 32 | Control word readback |
| deep_en_i | input | 1 | Deep mode: enforce the minimum off time |
| sleep_req_i | input | 1 | Request to remove the supply |
| wake_req_i | input | 1 | Request to restore the supply |
| supply_en_o | output | 1 | Core supply enable |

## Verification
A wrong state or counter value in this block shows up at supply_en_o in one of two ways: the supply returns on the wrong edge, or it never returns. The bench therefore measures the exact edge on which the enable rises for a range of select and count settings. A prescaler that skips or repeats a tick moves that edge by a whole tick period. A lost wakeup latch leaves the enable low indefinitely, and the bench's cycle limit catches that within a few hundred cycles. Register-layout faults are visible at once on the readback port after each write.

// File: rtl/dsl_pkg.sv
`timescale 1ns/1ps
package dsl_pkg;
    localparam int unsigned WORD_W  = 32;
    localparam int unsigned SEL_W   = 5;
    localparam int unsigned CNT_W   = 8;
    localparam int unsigned PRE_W   = 31;
    localparam int unsigned SEL_LSB = 24;
    localparam int unsigned CNT_LSB = 16;
    localparam logic [SEL_W-1:0] SEL_RST = 5'd8;
    localparam logic [CNT_W-1:0] CNT_RST = 8'd16;

    typedef enum logic [1:0] {
        ST_POWER_ON  = 2'd0,
        ST_OFF_HOLD  = 2'd1,
        ST_OFF_READY = 2'd2
    } pwr_state_t;
endpackage

// File: rtl/dsl_ctrl_reg.sv
`timescale 1ns/1ps
module dsl_ctrl_reg #(
    parameter int unsigned WORD_W  = dsl_pkg::WORD_W,
    parameter int unsigned SEL_W   = dsl_pkg::SEL_W,
    parameter int unsigned CNT_W   = dsl_pkg::CNT_W,
    parameter int unsigned SEL_LSB = dsl_pkg::SEL_LSB,
    parameter int unsigned CNT_LSB = dsl_pkg::CNT_LSB,
    parameter logic [SEL_W-1:0] SEL_RST = dsl_pkg::SEL_RST,
    parameter logic [CNT_W-1:0] CNT_RST = dsl_pkg::CNT_RST
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_data,
    output logic [SEL_W-1:0]  sel_q,
    output logic [CNT_W-1:0]  cnt_q,
    output logic [WORD_W-1:0] rd_data
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_q <= SEL_RST;
            cnt_q <= CNT_RST;
        end else if (wr_en) begin
            sel_q <= wr_data[SEL_LSB +: SEL_W];
            cnt_q <= wr_data[CNT_LSB +: CNT_W];
        end
    end

    always_comb begin
        rd_data = '0;
        rd_data[SEL_LSB +: SEL_W] = sel_q;
        rd_data[CNT_LSB +: CNT_W] = cnt_q;
    end

    // R1: a write lands in both fields on the next edge
    p_write_lands_r1: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (sel_q == $past(wr_data[SEL_LSB +: SEL_W]))
               && (cnt_q == $past(wr_data[CNT_LSB +: CNT_W])));
endmodule

// File: rtl/dsl_prescaler.sv
`timescale 1ns/1ps
module dsl_prescaler #(
    parameter int unsigned PRE_W = dsl_pkg::PRE_W,
    parameter int unsigned SEL_W = dsl_pkg::SEL_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             run,
    input  logic [SEL_W-1:0] sel,
    output logic             tick
);
    logic [PRE_W-1:0] acc_q;
    logic [PRE_W-1:0] mask;

    // bit i takes part in the tick compare when i < sel-1 (select 0 and 1: none)
    for (genvar i = 0; i < PRE_W; i++) begin : g_mask
        assign mask[i] = ((i + 1) < int'(sel));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      acc_q <= '0;
        else if (clr)    acc_q <= '0;
        else if (run)    acc_q <= acc_q + PRE_W'(1);
    end

    assign tick = run & (&(acc_q | ~mask));

    // R3: divide-by-one selects tick on every running cycle
    p_div1_every_cycle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (run && (sel <= SEL_W'(1))) |-> tick);

    // R8: a clear restarts the phase from zero
    p_clear_phase_r8: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (acc_q == '0));
endmodule

// File: rtl/dsl_offcount.sv
`timescale 1ns/1ps
module dsl_offcount #(
    parameter int unsigned CNT_W = dsl_pkg::CNT_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             dec,
    output logic             zero
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                   cnt_q <= '0;
        else if (load)                cnt_q <= load_val;
        else if (dec && cnt_q != '0)  cnt_q <= cnt_q - CNT_W'(1);
    end

    assign zero = (cnt_q == '0);

    // R8: every entry reloads the programmed count
    p_reload_r8: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (cnt_q == $past(load_val)));

    // R4: the count moves down by at most one per cycle and never wraps
    p_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && cnt_q != '0) |=> (cnt_q == $past(cnt_q)) || (cnt_q == $past(cnt_q) - CNT_W'(1)));
endmodule

// File: rtl/dsleep_offtime_timer.sv
`timescale 1ns/1ps
module dsleep_offtime_timer
    import dsl_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cfg_wr_en,
    input  logic [31:0] cfg_wr_data,
    output logic [31:0] cfg_rd_data,
    input  logic        deep_en_i,
    input  logic        sleep_req_i,
    input  logic        wake_req_i,
    output logic        supply_en_o
);
    pwr_state_t       state_q, state_d;
    logic [SEL_W-1:0] sel;
    logic [CNT_W-1:0] cnt_cfg;
    logic             tick;
    logic             cnt_zero;
    logic             enter_hold;
    logic             wake_pend_q;
    logic             wake_any;

    dsl_ctrl_reg u_reg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cfg_wr_en),
        .wr_data (cfg_wr_data),
        .sel_q   (sel),
        .cnt_q   (cnt_cfg),
        .rd_data (cfg_rd_data)
    );

    assign enter_hold = (state_q == ST_POWER_ON) && sleep_req_i && deep_en_i;

    dsl_prescaler u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (enter_hold),
        .run   (state_q == ST_OFF_HOLD),
        .sel   (sel),
        .tick  (tick)
    );

    dsl_offcount u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (enter_hold),
        .load_val (cnt_cfg),
        .dec      (tick),
        .zero     (cnt_zero)
    );

    // wakeups seen during the countdown are kept until the hold ends
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                       wake_pend_q <= 1'b0;
        else if (state_q == ST_OFF_HOLD)  wake_pend_q <= wake_pend_q | wake_req_i;
        else                              wake_pend_q <= 1'b0;
    end

    assign wake_any = wake_req_i | wake_pend_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_POWER_ON;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_POWER_ON: begin
                if (sleep_req_i) state_d = deep_en_i ? ST_OFF_HOLD : ST_OFF_READY;
            end
            ST_OFF_HOLD: begin
                if (cnt_zero) state_d = wake_any ? ST_POWER_ON : ST_OFF_READY;
            end
            ST_OFF_READY: begin
                if (wake_req_i) state_d = ST_POWER_ON;
            end
            default: state_d = ST_POWER_ON;
        endcase
    end

    always_comb begin
        supply_en_o = (state_q == ST_POWER_ON);
    end

    // R2: a sleep request with the supply on removes it on the next edge
    p_enter_drop_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (supply_en_o && sleep_req_i) |=> !supply_en_o);

    // R5: no wakeup is honoured while the count is still running
    p_hold_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_OFF_HOLD && !cnt_zero) |=> !supply_en_o);

    // R5: a latched wakeup is served once the count has expired
    p_pending_served_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_OFF_HOLD && cnt_zero && wake_pend_q) |=> supply_en_o);

    // R7: a wakeup in the ready state restores the supply at once
    p_ready_wake_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_OFF_READY && wake_req_i) |=> supply_en_o);

    // R9: with no wakeup, the ready state holds the supply off
    p_ready_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_OFF_READY && !wake_req_i) |=> !supply_en_o);
endmodule

// File: tb/dsleep_offtime_timer_tb.sv
`timescale 1ns/1ps
module dsleep_offtime_timer_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr_en = 1'b0;
    logic [31:0] cfg_wr_data = '0;
    logic [31:0] cfg_rd_data;
    logic        deep_en = 1'b0;
    logic        sleep_req = 1'b0;
    logic        wake_req = 1'b0;
    logic        supply_en;

    always #2.5 clk = ~clk;

    dsleep_offtime_timer dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_wr_en   (cfg_wr_en),
        .cfg_wr_data (cfg_wr_data),
        .cfg_rd_data (cfg_rd_data),
        .deep_en_i   (deep_en),
        .sleep_req_i (sleep_req),
        .wake_req_i  (wake_req),
        .supply_en_o (supply_en)
    );

    typedef struct packed {
        logic [4:0]  sel;
        logic [7:0]  cnt;
        logic        deep;
        int unsigned exp_edges;
    } vec_t;

    // expected edge = deep ? cnt * 2^(max(sel,1)-1) + 1 : 1
    localparam vec_t VECS [9] = '{
        '{5'd1, 8'd5, 1'b1, 6},     // R3 divide by one
        '{5'd2, 8'd3, 1'b1, 7},     // R3 divide by two
        '{5'd3, 8'd4, 1'b1, 17},    // R4
        '{5'd0, 8'd3, 1'b1, 4},     // R3 reserved select acts as one
        '{5'd1, 8'd0, 1'b1, 1},     // R6 zero count
        '{5'd5, 8'd3, 1'b0, 1},     // R7 deep mode clear
        '{5'd8, 8'd2, 1'b1, 257},   // R4 reset-default select
        '{5'd3, 8'd4, 1'b1, 17},    // R8 repeat gives same off time
        '{5'd4, 8'd1, 1'b1, 9}      // R4
    };

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
        end
    endtask

    task automatic cfg_write(input logic [31:0] w);
        @(negedge clk);
        cfg_wr_en = 1'b1;
        cfg_wr_data = w;
        @(negedge clk);
        cfg_wr_en = 1'b0;
        cfg_wr_data = '0;
    endtask

    // enter sleep, optionally pulse a wakeup sampled at the first edge after entry,
    // and count edges until the supply is back (or the limit is hit)
    task automatic sleep_cycle(input logic d, input bit pulse, input int limit, output int k);
        @(negedge clk);
        deep_en = d;
        sleep_req = 1'b1;
        @(negedge clk);
        sleep_req = 1'b0;
        check(!supply_en, "R2 supply low after entry", {31'b0, supply_en}, 32'd0);
        wake_req = pulse;
        k = 0;
        while (k < limit) begin
            @(negedge clk);
            wake_req = 1'b0;
            k++;
            if (supply_en) break;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        int k;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset value, R2 supply on after reset
        check(cfg_rd_data == 32'h0810_0000, "R1 reset readback", cfg_rd_data, 32'h0810_0000);
        check(supply_en == 1'b1, "R2 supply on after reset", {31'b0, supply_en}, 32'd1);

        // table walk
        for (int i = 0; i < 9; i++) begin
            logic [31:0] w;
            string tag;
            w = {3'b000, VECS[i].sel, VECS[i].cnt, 16'h0000};
            cfg_write(w);
            check(cfg_rd_data == w, "R1 field readback", cfg_rd_data, w);
            if (!VECS[i].deep)          tag = "R7 shallow wake";
            else if (VECS[i].cnt == 0)  tag = "R6 zero count";
            else if (VECS[i].sel <= 1)  tag = "R3 tick period";
            else                        tag = "R4 off time (R5 latched wake)";
            sleep_cycle(VECS[i].deep, 1'b1, 2000, k);
            check(k == int'(VECS[i].exp_edges), tag, k, VECS[i].exp_edges);
        end

        // R1 reserved bits read zero
        cfg_write(32'hFFFF_FFFF);
        check(cfg_rd_data == 32'h1FFF_0000, "R1 reserved bits", cfg_rd_data, 32'h1FFF_0000);

        // R9: expiry with no wakeup keeps the supply off
        cfg_write({3'b000, 5'd1, 8'd2, 16'h0000});
        sleep_cycle(1'b1, 1'b0, 10, k);
        check(!supply_en, "R9 stays off without wake", {31'b0, supply_en}, 32'd0);
        // R7: wakeup in the ready state restores on the next edge
        @(negedge clk);
        wake_req = 1'b1;
        @(negedge clk);
        wake_req = 1'b0;
        check(supply_en, "R7 ready-state wake", {31'b0, supply_en}, 32'd1);

        // R5: a wakeup held high through the countdown still waits for expiry
        cfg_write({3'b000, 5'd2, 8'd2, 16'h0000});
        @(negedge clk);
        deep_en = 1'b1;
        sleep_req = 1'b1;
        @(negedge clk);
        sleep_req = 1'b0;
        wake_req = 1'b1;
        repeat (4) @(negedge clk);
        check(!supply_en, "R5 held wake ignored during count", {31'b0, supply_en}, 32'd0);
        @(negedge clk);
        wake_req = 1'b0;
        check(supply_en, "R5 wake served at expiry", {31'b0, supply_en}, 32'd1);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule